// File: doc/BRIEF.md
# Sector Cache with Per-Sub-Block Valid Bits

This block is a read-only, direct-mapped cache in which each line holds a single tag shared by several sub-blocks, and each sub-block has its own valid bit. Sharing one tag across a whole line keeps tag storage small. Memory traffic stays at the size of one sub-block, because a miss fetches only the word that was asked for and not the whole line.

The CPU side accepts a word address with a valid/ready handshake and returns the word with a one-cycle response pulse. A lookup hits only when two conditions are met: the stored tag equals the address tag, and the valid bit of the addressed sub-block is set. On a miss the block raises a memory request that carries the missing word address. It holds that request until the refill word arrives, and keeps its CPU port not ready for that whole time. When the word arrives, the block installs it and forwards it to the CPU. If the refill comes from a different tag, the line is taken over by the new tag and its other sub-blocks are invalidated. If the tag matches, the new sub-block is added next to the sub-blocks that are already valid.

Top module: `sector_cache`

## Requirements
- R1: After a synchronous active-low reset, every sub-block valid bit is clear. The outputs are then cpu_req_ready=1, cpu_resp_valid=0 and mem_req_valid=0, so the first read of any address misses.
- R2: A word address is split as follows. Bits [SUB_BITS-1:0] select the sub-block (one word each). The next INDEX_W bits select the line. All remaining upper bits form the tag.
- R3: An accepted read hits only when the line tag equals the address tag and the addressed sub-block is valid. A hit raises cpu_resp_valid with the stored word on the cycle after acceptance, and raises no memory request.
- R4: An accepted read that misses raises mem_req_valid from the next cycle, with mem_req_addr equal to the full word address. Exactly one sub-block is requested.
- R5: When a refill comes from a tag that differs from the line tag, the line takes the new tag and every other sub-block of the line becomes invalid.
- R6: When a refill comes from a tag equal to the line tag, the sub-blocks that were already valid stay valid, and the refilled sub-block is added to them.
- R7: Only one miss is outstanding at a time. While mem_req_valid is high, cpu_req_ready is low, and mem_req_addr stays stable until mem_resp_valid.
- R8: On the cycle after mem_resp_valid, cpu_resp_valid pulses with the refill word, and cpu_req_ready is high again. A later hit on that address returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU read request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_addr | input | ADDR_W | Word address of the read |
| cpu_resp_valid | output | 1 | One-cycle pulse with read data |
| cpu_resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Refill request outstanding |
| mem_req_addr | output | ADDR_W | Word address of the sub-block to fetch |
| mem_resp_valid | input | 1 | Refill word present (only while a request is outstanding) |
| mem_resp_data | input | DATA_W | Refill word |

## Verification
Several properties are checked on every cycle by assertions. A request stalls while it is outstanding, and its address stays stable. An accepted hit produces a response with no memory traffic, and an accepted miss produces a request. A refill after a tag change leaves exactly one valid sub-block in the line. A refill under the same tag never drops a valid sub-block. Other behaviours can only be shown by the bench's read sequences checked against a reference model: the correct address split, hits on sibling sub-blocks after a same-tag refill, misses on siblings after a line has been taken over, and the returned data matching memory.

// File: rtl/sc_pkg.sv
// Shared types for the sector cache.
// Assumes: a single outstanding miss, so two controller states are enough.
package sc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MISS = 1'b1
    } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
// Tag array and per-sub-block valid bits for a direct-mapped sector cache.
// Performs the combinational lookup and the update on a refill.
// Assumes: fill_en arrives only for the address that missed.
module sc_tag_store #(
    parameter int ADDR_W   = 12,
    parameter int INDEX_W  = 3,
    parameter int SUB_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr
);
    localparam int LINES = 1 << INDEX_W;
    localparam int SUBS  = 1 << SUB_BITS;
    localparam int TAG_W = ADDR_W - INDEX_W - SUB_BITS;

    logic [TAG_W-1:0] tags [LINES];
    logic [SUBS-1:0]  vld  [LINES];

    logic [INDEX_W-1:0]  lk_idx, fill_idx;
    logic [SUB_BITS-1:0] lk_sub, fill_sub;
    logic [TAG_W-1:0]    lk_tag, fill_tag;
    logic                fill_tag_match;
    logic [SUBS-1:0]     fill_line_vld;

    // Split the lookup and refill addresses into tag, index and sub-block.
    always_comb begin
        lk_sub         = lk_addr[SUB_BITS-1:0];
        lk_idx         = lk_addr[SUB_BITS +: INDEX_W];
        lk_tag         = lk_addr[ADDR_W-1 -: TAG_W];
        fill_sub       = fill_addr[SUB_BITS-1:0];
        fill_idx       = fill_addr[SUB_BITS +: INDEX_W];
        fill_tag       = fill_addr[ADDR_W-1 -: TAG_W];
        fill_tag_match = (tags[fill_idx] == fill_tag);
        fill_line_vld  = vld[fill_idx];
    end

    // A hit needs both a tag match and a valid sub-block.
    always_comb lk_hit = (tags[lk_idx] == lk_tag) && vld[lk_idx][lk_sub];

    // Clear the valid bits on reset; on a refill, add the sub-block or take over the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) vld[i] <= '0;
        end else if (fill_en) begin
            if (fill_tag_match) begin
                vld[fill_idx][fill_sub] <= 1'b1;
            end else begin
                tags[fill_idx] <= fill_tag;
                vld[fill_idx]  <= SUBS'(1) << fill_sub;
            end
        end
    end

    // R5
    replace_one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_tag_match) |=> ($countones(vld[$past(fill_idx)]) == 1));

    // R6
    keep_siblings_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_tag_match) |=>
        ((vld[$past(fill_idx)] & $past(fill_line_vld)) == $past(fill_line_vld)));
endmodule

// File: rtl/sc_data_store.sv
// Word storage for the sector cache, with one entry per sub-block of every line.
// Assumes: reads are combinational and one word is written per refill.
module sc_data_store #(
    parameter int ADDR_W   = 12,
    parameter int INDEX_W  = 3,
    parameter int SUB_BITS = 2,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SLOT_W = INDEX_W + SUB_BITS;
    localparam int SLOTS  = 1 << SLOT_W;

    logic [DATA_W-1:0] words [SLOTS];

    // Read the slot chosen by the index and sub-block bits.
    always_comb rd_data = words[rd_addr[SLOT_W-1:0]];

    // Store the refill word in its slot.
    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr[SLOT_W-1:0]] <= wr_data;
    end
endmodule

// File: rtl/sc_ctrl.sv
// Request sequencing: accepts a read, answers a hit at once, and otherwise
// holds a single refill request until the word returns.
// Assumes: mem_resp_valid is driven only while mem_req_valid is high.
module sc_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              fill_en
);
    import sc_pkg::*;

    sc_state_e         state;
    logic [ADDR_W-1:0] miss_addr;
    logic              accept;

    // Handshake and refill strobes.
    always_comb begin
        cpu_req_ready = (state == ST_IDLE);
        accept        = cpu_req_valid && cpu_req_ready;
        mem_req_valid = (state == ST_MISS);
        mem_req_addr  = miss_addr;
        fill_en       = mem_req_valid && mem_resp_valid;
    end

    // State sequence, latch of the miss address, and the registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            cpu_resp_valid <= 1'b0;
            cpu_resp_data  <= '0;
            miss_addr      <= '0;
        end else begin
            cpu_resp_valid <= 1'b0;
            if (accept) begin
                if (lk_hit) begin
                    cpu_resp_valid <= 1'b1;
                    cpu_resp_data  <= lk_data;
                end else begin
                    state     <= ST_MISS;
                    miss_addr <= cpu_req_addr;
                end
            end else if (fill_en) begin
                cpu_resp_valid <= 1'b1;
                cpu_resp_data  <= mem_resp_data;
                state          <= ST_IDLE;
            end
        end
    end

    // R3
    hit_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (cpu_resp_valid && !mem_req_valid));

    // R4
    miss_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (mem_req_valid && mem_req_addr == $past(cpu_req_addr)));

    // R7
    stall_while_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8
    refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (cpu_resp_valid && cpu_req_ready && cpu_resp_data == $past(mem_resp_data)));
endmodule

// File: rtl/sector_cache.sv
// Direct-mapped read cache with one tag per line and one valid bit per
// sub-block; a miss fetches a single sub-block.
// Assumes: one outstanding miss and memory that answers every request once.
module sector_cache #(
    parameter int ADDR_W   = 12,
    parameter int INDEX_W  = 3,
    parameter int SUB_BITS = 2,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data
);
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              fill_en;

    sc_tag_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .SUB_BITS(SUB_BITS)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(cpu_req_addr), .lk_hit(lk_hit),
        .fill_en(fill_en), .fill_addr(mem_req_addr)
    );

    sc_data_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .SUB_BITS(SUB_BITS),
                    .DATA_W(DATA_W)) data_i (
        .clk(clk),
        .rd_addr(cpu_req_addr), .rd_data(lk_data),
        .wr_en(fill_en), .wr_addr(mem_req_addr), .wr_data(mem_resp_data)
    );

    sc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_data(cpu_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .lk_hit(lk_hit), .lk_data(lk_data), .fill_en(fill_en)
    );
endmodule

// File: tb/sector_cache_tb.sv
// Bench for the sector cache: directed corner cases followed by seeded random
// reads, each checked against a reference model of tags and sub-block valids.
module sector_cache_tb_top;
    localparam int ADDR_W   = 12;
    localparam int INDEX_W  = 3;
    localparam int SUB_BITS = 2;
    localparam int DATA_W   = 32;
    localparam int LINES    = 1 << INDEX_W;
    localparam int SUBS     = 1 << SUB_BITS;
    localparam int TAG_W    = ADDR_W - INDEX_W - SUB_BITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_data;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_resp_valid = 1'b0;
    logic [DATA_W-1:0] mem_resp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [TAG_W-1:0] m_tag [LINES];
    logic [SUBS-1:0]  m_vld [LINES];

    always #5 clk = ~clk;

    sector_cache #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .SUB_BITS(SUB_BITS),
                   .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_data(cpu_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return (DATA_W'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic model_hit(input logic [ADDR_W-1:0] a);
        logic [INDEX_W-1:0] idx = a[SUB_BITS +: INDEX_W];
        return (m_tag[idx] == a[ADDR_W-1 -: TAG_W]) && m_vld[idx][a[SUB_BITS-1:0]];
    endfunction

    task automatic check(input logic ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One read: hit or miss decided by the model; memory answers after `lat` cycles.
    task automatic do_read(input logic [ADDR_W-1:0] a, input int lat, input string req);
        logic exp_hit = model_hit(a);
        logic [INDEX_W-1:0] idx = a[SUB_BITS +: INDEX_W];
        logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (exp_hit) begin
            check(cpu_resp_valid && !mem_req_valid, {req, " R3 hit response"},
                  {cpu_resp_valid, mem_req_valid}, 2'b10);
            check(cpu_resp_data == mem_word(a), {req, " R8 hit data"}, cpu_resp_data, mem_word(a));
        end else begin
            check(mem_req_valid && !cpu_resp_valid, {req, " R4 miss request"},
                  {mem_req_valid, cpu_resp_valid}, 2'b10);
            check(mem_req_addr == a, {req, " R4 R2 request address"}, mem_req_addr, a);
            for (int i = 0; i < lat; i++) begin
                check(mem_req_valid && !cpu_req_ready && mem_req_addr == a, {req, " R7 stall"},
                      {mem_req_valid, cpu_req_ready}, 2'b10);
                @(negedge clk);
            end
            check(!cpu_req_ready, {req, " R7 ready low"}, cpu_req_ready, 1'b0);
            mem_resp_valid = 1'b1;
            mem_resp_data  = mem_word(a);
            @(negedge clk);
            mem_resp_valid = 1'b0;
            check(cpu_resp_valid && cpu_req_ready && !mem_req_valid, {req, " R8 refill response"},
                  {cpu_resp_valid, cpu_req_ready, mem_req_valid}, 3'b110);
            check(cpu_resp_data == mem_word(a), {req, " R8 refill data"}, cpu_resp_data, mem_word(a));
            if (m_tag[idx] == tg) begin
                m_vld[idx][a[SUB_BITS-1:0]] = 1'b1;
            end else begin
                m_tag[idx] = tg;
                m_vld[idx] = SUBS'(1) << a[SUB_BITS-1:0];
            end
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int idx, input int sub);
        return {TAG_W'(tg), INDEX_W'(idx), SUB_BITS'(sub)};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = '0;
            m_vld[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 reset outputs",
              {cpu_req_ready, cpu_resp_valid, mem_req_valid}, 3'b100);
        // R1: tag 0 with cleared valids must still miss
        do_read(mk(0, 0, 0), 0, "R1 cold read tag0");
        do_read(mk(0, 0, 0), 0, "R3 repeat");
        // R6: sibling under same tag added, first one kept
        do_read(mk(0, 0, 2), 2, "R6 sibling fill");
        do_read(mk(0, 0, 0), 0, "R6 kept sibling");
        do_read(mk(0, 0, 2), 0, "R6 new sibling");
        do_read(mk(0, 0, 1), 1, "R6 third sibling");
        // R5: different tag takes the line over; old siblings gone
        do_read(mk(5, 0, 1), 3, "R5 takeover");
        do_read(mk(5, 0, 2), 0, "R5 sibling invalid under new tag");
        do_read(mk(0, 0, 0), 1, "R5 old tag evicted");
        // R2: neighbouring lines are independent
        do_read(mk(0, 7, 3), 0, "R2 top line");
        do_read(mk(0, 1, 3), 0, "R2 other line");
        do_read(mk(0, 7, 3), 0, "R2 top line hit");
        // Random reads over a few tags to force conflicts
        for (int n = 0; n < 600; n++) begin
            do_read(mk($urandom_range(0, 2), $urandom_range(0, LINES - 1),
                       $urandom_range(0, SUBS - 1)), $urandom_range(0, 3), "random R3 R5 R6");
        end
        // R1: reset again clears valids
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) m_vld[i] = '0;
        do_read(mk(0, 7, 3), 0, "R1 miss after second reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule